// File: doc/BRIEF.md
# Programmable PCI Interrupt Link Router

This block steers level-sensitive PCI device interrupts onto a 16-line legacy IRQ vector. It does this through eight programmable link registers. Each link register holds a disable flag and a 4-bit IRQ selector. Each link also keeps a count of how many device sources are currently asserting through it, so several devices can share one link. The selected legacy IRQ line is driven while that count is nonzero and the link holds a usable setting.

Devices report interrupt changes as single-cycle events. Each event carries an assert/deassert flag, a link pin number and a direct controller line number. Pin number 0 skips the links entirely. Such an event raises or lowers its direct line through a per-line counter of its own, so a shared direct line stays high until its last source drops.

Software-side accesses to the link registers arrive as plain write strobes and a combinational read port, addressed by pin number 1 to 8.

Top module: `irq_link_router`

## Requirements
- R1: After reset, every link register reads 0x80, both output vectors are all zero, and `cnt_err` is low.
- R2: A write to pin p (1..8) stores `wdata & 0x8F`. `rdata` returns the stored value of the pin on `reg_addr`. A write to address 0 or above 8 changes no register, and a read there returns 0x00.
- R3: Take a link whose bit 7 is clear and whose bits 3:0 name a permitted IRQ (3–7, 9–12, 14, 15; mask 0xDEF8). While that link's count is nonzero, `isa_irq[bits 3:0]` is high from the clock edge that applied the event.
- R4: A link with bit 7 set, or with IRQ 0, 1, 2, 8 or 13, drives no `isa_irq` bit whatever its count. No non-permitted `isa_irq` bit is ever high.
- R5: An assert event on pin p adds one to that link's count and a deassert subtracts one. The IRQ stays high until the count returns to zero.
- R6: Rewriting an active link's register moves the driven level from the old IRQ to the new one on the same edge. A write that leaves the stored value unchanged leaves the outputs unchanged.
- R7: Each `isa_irq` bit is the OR of all valid, active links mapped to it.
- R8: An event with pin 0 counts on `ioapic_irq[line]` only. That line is high while its count is nonzero. Such an event never alters `isa_irq`.
- R9: Counts are 8 bits. A deassert at 0, or an assert at 255, leaves the count unchanged and raises `cnt_err` for exactly the next cycle.
- R10: A register write and an event in the same cycle both take effect on that edge. The event's link uses the newly written setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Link register write strobe |
| reg_addr | input | 4 | Link pin number for read and write (1..8 valid) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored value of the addressed link |
| ev_valid | input | 1 | Device event strobe |
| ev_assert | input | 1 | 1 = assert, 0 = deassert |
| ev_pin | input | 4 | Link pin (0 = direct line bypass) |
| ev_line | input | 4 | Direct controller line used when ev_pin is 0 |
| isa_irq | output | 16 | Legacy IRQ level vector |
| ioapic_irq | output | 16 | Direct controller line level vector |
| cnt_err | output | 1 | One-cycle pulse on counter underflow or overflow |

## Verification
The hardest case to reach is overflow. A link count must be pushed to its 8-bit ceiling, so the stimulus issues 255 back-to-back assert events on one link before the 256th. It then issues 255 deasserts and checks that the IRQ drops on exactly the last one, which proves the rejected assert left the count intact. A second hard case is retargeting a link while it is active. The bench holds a link asserted and rewrites its register through all sixteen IRQ numbers and the disable flag, checking each move of the level.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned LINKS_DEF  = 8;
    localparam int unsigned LINES_DEF  = 16;
    localparam int unsigned CNT_W_DEF  = 8;
    localparam logic [15:0] PERMIT_MASK = 16'hDEF8;
    localparam logic [7:0]  KEEP_MASK   = 8'h8F;
    localparam logic [7:0]  LINK_RESET  = 8'h80;

    function automatic logic link_usable(input logic [7:0] setting);
        return !setting[7] && PERMIT_MASK[setting[3:0]];
    endfunction
endpackage

// File: rtl/pirq_sat_counter.sv
module pirq_sat_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        err_o   = 1'b0;
        if (inc_i && !dec_i) begin
            if (state_q.cnt == TOP) err_o = 1'b1;
            else                    state_d.cnt = state_q.cnt + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (state_q.cnt == '0)  err_o = 1'b1;
            else                    state_d.cnt = state_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt_o  = state_q.cnt;
    assign busy_o = (state_q.cnt != '0);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && cnt_o == '0) |=> (cnt_o == '0));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && cnt_o == TOP) |=> (cnt_o == TOP));
    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && cnt_o != TOP) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pirq_link_bank.sv
module pirq_link_bank
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINKS = LINKS_DEF,
    parameter int unsigned ADDR_W  = $clog2(N_LINKS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [7:0]              wdata_i,
    output logic [7:0]              rdata_o,
    output logic [N_LINKS-1:0][7:0] links_o
);
    typedef struct packed {
        logic [N_LINKS-1:0][7:0] link;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < N_LINKS; i++) begin
            if (we_i && addr_i == ADDR_W'(i + 1))
                state_d.link[i] = wdata_i & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= {N_LINKS{LINK_RESET}};
        else        state_q <= state_d;
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < N_LINKS; i++) begin
            if (addr_i == ADDR_W'(i + 1)) rdata_o = state_q.link[i];
        end
    end

    assign links_o = state_q.link;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_chk
        // R2
        link_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == ADDR_W'(g + 1)) |=> (links_o[g] == ($past(wdata_i) & KEEP_MASK)));
        // R2
        link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && addr_i == ADDR_W'(g + 1)) |=> $stable(links_o[g]));
    end
endmodule

// File: rtl/pirq_isa_merge.sv
module pirq_isa_merge
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINKS = LINKS_DEF,
    parameter int unsigned N_IRQ   = 16
) (
    input  logic [N_LINKS-1:0][7:0] links_i,
    input  logic [N_LINKS-1:0]      busy_i,
    output logic [N_IRQ-1:0]        isa_o
);
    logic [N_LINKS-1:0][N_IRQ-1:0] onehot;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        always_comb begin
            onehot[g] = '0;
            if (busy_i[g] && link_usable(links_i[g]))
                onehot[g][links_i[g][3:0]] = 1'b1;
        end
    end

    always_comb begin
        isa_o = '0;
        for (int i = 0; i < N_LINKS; i++) isa_o |= onehot[i];
    end
endmodule

// File: rtl/irq_link_router.sv
module irq_link_router
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINKS = LINKS_DEF,
    parameter int unsigned N_LINES = LINES_DEF,
    parameter int unsigned CNT_W   = CNT_W_DEF,
    parameter int unsigned PIN_W   = $clog2(N_LINKS + 1),
    parameter int unsigned LINE_W  = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [PIN_W-1:0]  reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ev_valid,
    input  logic              ev_assert,
    input  logic [PIN_W-1:0]  ev_pin,
    input  logic [LINE_W-1:0] ev_line,
    output logic [15:0]       isa_irq,
    output logic [N_LINES-1:0] ioapic_irq,
    output logic              cnt_err
);
    typedef struct packed {
        logic err;
    } state_t;

    state_t state_d, state_q;

    logic [N_LINKS-1:0][7:0] links;
    logic [N_LINKS-1:0]      link_busy, link_err;
    logic [N_LINES-1:0]      line_err;

    pirq_link_bank #(.N_LINKS(N_LINKS), .ADDR_W(PIN_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .links_o(links)
    );

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        logic hit;
        logic [CNT_W-1:0] cnt;
        assign hit = ev_valid && (ev_pin == PIN_W'(g + 1));
        pirq_sat_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc_i(hit && ev_assert), .dec_i(hit && !ev_assert),
            .cnt_o(cnt), .busy_o(link_busy[g]), .err_o(link_err[g])
        );
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic hit;
        logic [CNT_W-1:0] cnt;
        assign hit = ev_valid && (ev_pin == '0) && (ev_line == LINE_W'(g));
        pirq_sat_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc_i(hit && ev_assert), .dec_i(hit && !ev_assert),
            .cnt_o(cnt), .busy_o(ioapic_irq[g]), .err_o(line_err[g])
        );
    end

    pirq_isa_merge #(.N_LINKS(N_LINKS), .N_IRQ(16)) i_merge (
        .links_i(links), .busy_i(link_busy), .isa_o(isa_irq)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = (|link_err) || (|line_err);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt_err = state_q.err;

    // R4
    only_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isa_irq & ~PERMIT_MASK) == 16'h0);
    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_err && !ev_valid) |=> !cnt_err);
    // R8
    bypass_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_pin == '0 && !reg_we) |=> $stable(isa_irq));
    for (genvar g = 0; g < N_LINKS; g++) begin : g_a
        // R3
        active_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (link_busy[g] && link_usable(links[g])) |-> isa_irq[links[g][3:0]]);
    end
endmodule

// File: tb/test_irq_link_router.sv
module test_irq_link_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic ev_valid = 1'b0, ev_assert = 1'b0;
    logic [3:0] ev_pin = '0, ev_line = '0;
    logic [15:0] isa_irq, ioapic_irq;
    logic cnt_err;

    always #2 clk = ~clk;

    irq_link_router i_irq_link_router (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_assert(ev_assert), .ev_pin(ev_pin), .ev_line(ev_line),
        .isa_irq(isa_irq), .ioapic_irq(ioapic_irq), .cnt_err(cnt_err)
    );

    typedef struct {
        string tag;
        logic [15:0] isa;
        logic [15:0] ioa;
        logic [7:0]  rd;
        logic        err;
    } exp_t;

    exp_t q[$];
    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] m_reg [1:8];
    int m_cnt [1:8];
    int m_io [0:15];
    localparam logic [15:0] OK_IRQ = 16'hDEF8;

    function automatic logic [15:0] model_isa();
        logic [15:0] v = '0;
        for (int p = 1; p <= 8; p++)
            if (m_cnt[p] > 0 && !m_reg[p][7] && OK_IRQ[m_reg[p][3:0]]) v[m_reg[p][3:0]] = 1'b1;
        return v;
    endfunction

    function automatic logic [15:0] model_ioa();
        logic [15:0] v = '0;
        for (int l = 0; l < 16; l++) v[l] = (m_io[l] > 0);
        return v;
    endfunction

    task automatic step(input string tag, input bit we, input logic [3:0] a,
                        input logic [7:0] wd, input bit ev, input bit as,
                        input logic [3:0] pin, input logic [3:0] line);
        exp_t e;
        bit er = 0;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        ev_valid = ev; ev_assert = as; ev_pin = pin; ev_line = line;
        if (we && a >= 1 && a <= 8) m_reg[a] = wd & 8'h8F;
        if (ev && pin >= 1 && pin <= 8) begin
            if (as) begin if (m_cnt[pin] == 255) er = 1; else m_cnt[pin]++; end
            else    begin if (m_cnt[pin] == 0)   er = 1; else m_cnt[pin]--; end
        end else if (ev && pin == 0) begin
            if (as) begin if (m_io[line] == 255) er = 1; else m_io[line]++; end
            else    begin if (m_io[line] == 0)   er = 1; else m_io[line]--; end
        end
        e.tag = tag; e.isa = model_isa(); e.ioa = model_ioa(); e.err = er;
        e.rd = (a >= 1 && a <= 8) ? m_reg[a] : 8'h00;
        q.push_back(e);
    endtask

    task automatic rd(input string tag, input logic [3:0] a);
        step(tag, 0, a, 8'h00, 0, 0, 4'd0, 4'd0);
    endtask

    // monitor: pops expected items one edge after they were driven
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                tests++;
                if (isa_irq !== e.isa || ioapic_irq !== e.ioa || reg_rdata !== e.rd || cnt_err !== e.err) begin
                    fails++;
                    $display("FAIL %s: isa=%h ioa=%h rd=%h err=%b expected isa=%h ioa=%h rd=%h err=%b",
                             e.tag, isa_irq, ioapic_irq, reg_rdata, cnt_err, e.isa, e.ioa, e.rd, e.err);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 1; p <= 8; p++) begin m_reg[p] = 8'h80; m_cnt[p] = 0; end
        for (int l = 0; l < 16; l++) m_io[l] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, R2 out-of-range reads
        for (int p = 0; p <= 9; p++) rd("R1", 4'(p));
        // R2 masking and ignored addresses
        step("R2", 1, 4'd1, 8'hFF, 0, 0, 0, 0);
        step("R2", 1, 4'd0, 8'h05, 0, 0, 0, 0);
        step("R2", 1, 4'd9, 8'h05, 0, 0, 0, 0);
        for (int p = 1; p <= 8; p++) rd("R2", 4'(p));
        step("R2", 1, 4'd1, 8'h75, 0, 0, 0, 0);
        // R3 single source
        step("R3", 0, 4'd1, 0, 1, 1, 4'd1, 0);
        // R5 sharing
        step("R5", 0, 4'd1, 0, 1, 1, 4'd1, 0);
        step("R5", 0, 4'd1, 0, 1, 0, 4'd1, 0);
        step("R5", 0, 4'd1, 0, 1, 0, 4'd1, 0);
        // R4 reserved IRQ acts as disabled
        step("R4", 1, 4'd2, 8'h08, 0, 0, 0, 0);
        step("R4", 0, 4'd2, 0, 1, 1, 4'd2, 0);
        // R6 retarget while active, R4 across every IRQ number
        for (int i = 0; i < 16; i++) step("R6", 1, 4'd2, 8'(i), 0, 0, 0, 0);
        step("R4", 1, 4'd2, 8'h8B, 0, 0, 0, 0);
        step("R6", 1, 4'd2, 8'h0B, 0, 0, 0, 0);
        step("R6", 1, 4'd2, 8'h7B, 0, 0, 0, 0);
        // R7 two links on one IRQ
        step("R7", 1, 4'd3, 8'h0B, 0, 0, 0, 0);
        step("R7", 0, 4'd3, 0, 1, 1, 4'd3, 0);
        step("R7", 0, 4'd3, 0, 1, 0, 4'd2, 0);
        step("R7", 0, 4'd3, 0, 1, 0, 4'd3, 0);
        // R8 bypass
        step("R8", 0, 4'd0, 0, 1, 1, 4'd0, 4'd4);
        step("R8", 0, 4'd0, 0, 1, 1, 4'd0, 4'd4);
        step("R8", 0, 4'd0, 0, 1, 0, 4'd0, 4'd4);
        step("R8", 0, 4'd0, 0, 1, 1, 4'd0, 4'd15);
        step("R8", 0, 4'd0, 0, 1, 0, 4'd0, 4'd4);
        step("R8", 0, 4'd0, 0, 1, 0, 4'd0, 4'd15);
        // R9 underflow on a link and on a direct line
        step("R9", 0, 4'd4, 0, 1, 0, 4'd4, 0);
        rd("R9", 4'd4);
        step("R9", 0, 4'd0, 0, 1, 0, 4'd0, 4'd9);
        rd("R9", 4'd4);
        // R10 write and event in the same cycle
        step("R10", 1, 4'd5, 8'h0E, 1, 1, 4'd5, 0);
        step("R10", 1, 4'd5, 8'h0C, 1, 0, 4'd5, 0);
        // R9 overflow
        step("R9", 1, 4'd6, 8'h03, 0, 0, 0, 0);
        for (int i = 0; i < 256; i++) step("R9", 0, 4'd6, 0, 1, 1, 4'd6, 0);
        rd("R9", 4'd6);
        for (int i = 0; i < 255; i++) step("R9", 0, 4'd6, 0, 1, 0, 4'd6, 0);
        rd("R9", 4'd6);
        @(negedge clk);
        reg_we = 0; ev_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule